// File: doc/BRIEF.md
# Banked Plug-and-Play Device Configuration Registers

This block holds the configuration of a set of host-visible logical devices as byte-wide registers behind a two-port window. Port offset 0 selects a register index. Port offset 1 moves data to or from the register that the index names. One global register holds the current logical device number. Every other implemented index reaches that device's own bank of registers. The bank holds an enable bit, two 16-bit I/O base addresses, an interrupt number and an interrupt type.

Every device's stored settings leave the block as flat output vectors. Address decoding of host cycles and serial interrupt signalling are done elsewhere, and they read these vectors. A host or a setup sequencer configures a device as follows. It writes the device number, then writes each per-device index and value pair. After that it reads the values back through the same window.

Top module: `pnp_cfg_regs`

## Requirements
- R1: After reset, the index register and the device-number register are zero. Every device is inactive, and all base addresses, interrupt numbers and interrupt types are zero.
- R2: A write at offset 0 stores the full byte as the index. A read at offset 0 returns the stored index.
- R3: Index 0x07 is the device-number register. A data-port write stores the full byte, and a data-port read returns it.
- R4: Index 0x30 is the activate register of the selected device. Bit 0 drives that device's bit of `dev_active_o`. A readback returns only bit 0, and bits 7:1 read as zero.
- R5: Indices 0x60 and 0x61 are the high and low bytes of base address 0. Indices 0x62 and 0x63 are the high and low bytes of base address 1. Writing 0x02 to 0x60 and 0xF8 to 0x61 gives base 0 = 0x02F8. Each byte reads back as written.
- R6: Index 0x70 holds an 8-bit interrupt number for the selected device. It reads back in full and appears on `irq_num_o`.
- R7: Index 0x71 is the interrupt type. Bit 0 set means level and clear means edge, and it drives `irq_level_o`. Bit 1 set means inverted, and it drives `irq_invert_o`. Bits 7:2 read as zero.
- R8: A data-port write to a per-device index changes only the bank of the device named by the device-number register. The other banks keep their values.
- R9: A data-port read of an unimplemented index returns 0x00. A data-port write to an unimplemented index changes no device output.
- R10: A device number of NUM_DEV or more is still stored. In that state, per-device reads return 0x00 and per-device writes change no bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the port window |
| sel_i | input | 1 | Port offset: 0 selects the index port, 1 selects the data port |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the offset on `sel_i` (combinational) |
| dev_active_o | output | NUM_DEV | Activate flag for each device |
| base0_o | output | NUM_DEV*16 | Base address 0 for each device; device i is at bits [16i+15:16i] |
| base1_o | output | NUM_DEV*16 | Base address 1 for each device, packed the same way |
| irq_num_o | output | NUM_DEV*8 | Interrupt number for each device; device i is at bits [8i+7:8i] |
| irq_level_o | output | NUM_DEV | Interrupt trigger for each device: 1 is level, 0 is edge |
| irq_invert_o | output | NUM_DEV | Interrupt polarity for each device: 1 is inverted |

## Verification
The bench builds the block with the default NUM_DEV = 8. In that build the highest bank (device 7) and the first out-of-range device number (8 and above) both fit in one byte, so the edge of the bank range can be tested from both sides. Device numbers 9 and 7 are used to show that an out-of-range activate write leaves device 7's bank untouched. Devices 3 and 5 are used to show that banks do not share storage. The bench also resets the block in mid-run after device 3 has been configured, which confirms that the reset clears every bank.

// File: rtl/pnp_cfg_pkg.sv
package pnp_cfg_pkg;
  localparam logic [7:0] IDX_DEVNUM = 8'h07;
  localparam logic [7:0] IDX_ACT    = 8'h30;
  localparam logic [7:0] IDX_B0_HI  = 8'h60;
  localparam logic [7:0] IDX_B0_LO  = 8'h61;
  localparam logic [7:0] IDX_B1_HI  = 8'h62;
  localparam logic [7:0] IDX_B1_LO  = 8'h63;
  localparam logic [7:0] IDX_IRQNUM = 8'h70;
  localparam logic [7:0] IDX_IRQTYP = 8'h71;

  typedef enum int {
    F_ACT, F_B0_HI, F_B0_LO, F_B1_HI, F_B1_LO, F_IRQNUM, F_IRQTYP, F_COUNT
  } field_e;
  localparam int NUM_FIELDS = F_COUNT;

  typedef struct packed {
    logic        active;
    logic [15:0] base0;
    logic [15:0] base1;
    logic [7:0]  irq_num;
    logic [1:0]  irq_type;  // [0] level, [1] invert
  } dev_cfg_t;
endpackage

// File: rtl/pnp_index_decode.sv
module pnp_index_decode
  import pnp_cfg_pkg::*;
(
  input  logic [7:0]            idx_i,
  output logic                  devnum_hit_o,
  output logic [NUM_FIELDS-1:0] field_sel_o
);
  always_comb begin
    field_sel_o  = '0;
    devnum_hit_o = 1'b0;
    case (idx_i)
      IDX_DEVNUM: devnum_hit_o          = 1'b1;
      IDX_ACT:    field_sel_o[F_ACT]    = 1'b1;
      IDX_B0_HI:  field_sel_o[F_B0_HI]  = 1'b1;
      IDX_B0_LO:  field_sel_o[F_B0_LO]  = 1'b1;
      IDX_B1_HI:  field_sel_o[F_B1_HI]  = 1'b1;
      IDX_B1_LO:  field_sel_o[F_B1_LO]  = 1'b1;
      IDX_IRQNUM: field_sel_o[F_IRQNUM] = 1'b1;
      IDX_IRQTYP: field_sel_o[F_IRQTYP] = 1'b1;
      default: ;
    endcase
  end

  // R9
  always_comb begin
    decode_onehot_chk: assert ($onehot0({devnum_hit_o, field_sel_o}));
  end
endmodule

// File: rtl/pnp_dev_bank.sv
module pnp_dev_bank
  import pnp_cfg_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [NUM_FIELDS-1:0] field_sel_i,
  input  logic [7:0]            wdata_i,
  output dev_cfg_t              cfg_o,
  output logic [7:0]            rd_o
);
  dev_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (wr_i) begin
      if (field_sel_i[F_ACT])    cfg_q.active       <= wdata_i[0];
      if (field_sel_i[F_B0_HI])  cfg_q.base0[15:8]  <= wdata_i;
      if (field_sel_i[F_B0_LO])  cfg_q.base0[7:0]   <= wdata_i;
      if (field_sel_i[F_B1_HI])  cfg_q.base1[15:8]  <= wdata_i;
      if (field_sel_i[F_B1_LO])  cfg_q.base1[7:0]   <= wdata_i;
      if (field_sel_i[F_IRQNUM]) cfg_q.irq_num      <= wdata_i;
      if (field_sel_i[F_IRQTYP]) cfg_q.irq_type     <= wdata_i[1:0];
    end
  end

  always_comb begin
    rd_o = '0;
    if (field_sel_i[F_ACT])    rd_o = {7'd0, cfg_q.active};
    if (field_sel_i[F_B0_HI])  rd_o = cfg_q.base0[15:8];
    if (field_sel_i[F_B0_LO])  rd_o = cfg_q.base0[7:0];
    if (field_sel_i[F_B1_HI])  rd_o = cfg_q.base1[15:8];
    if (field_sel_i[F_B1_LO])  rd_o = cfg_q.base1[7:0];
    if (field_sel_i[F_IRQNUM]) rd_o = cfg_q.irq_num;
    if (field_sel_i[F_IRQTYP]) rd_o = {6'd0, cfg_q.irq_type};
  end

  assign cfg_o = cfg_q;

  // R8
  bank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(cfg_q));
endmodule

// File: rtl/pnp_cfg_regs.sv
module pnp_cfg_regs
  import pnp_cfg_pkg::*;
#(
  parameter int NUM_DEV = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic                  sel_i,
  input  logic [7:0]            wdata_i,
  output logic [7:0]            rdata_o,
  output logic [NUM_DEV-1:0]    dev_active_o,
  output logic [NUM_DEV*16-1:0] base0_o,
  output logic [NUM_DEV*16-1:0] base1_o,
  output logic [NUM_DEV*8-1:0]  irq_num_o,
  output logic [NUM_DEV-1:0]    irq_level_o,
  output logic [NUM_DEV-1:0]    irq_invert_o
);
  localparam int DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

  logic [7:0]            idx_q, devnum_q;
  logic                  devnum_hit;
  logic [NUM_FIELDS-1:0] field_sel;
  logic [NUM_DEV-1:0]    bank_hit;
  logic                  dev_valid;
  logic                  data_wr;
  logic [7:0]            bank_rd [NUM_DEV];
  dev_cfg_t              bank_cfg [NUM_DEV];
  logic [7:0]            rd_mux;

  assign data_wr = wr_en_i && sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      devnum_q <= '0;
    end else if (wr_en_i) begin
      if (!sel_i)          idx_q    <= wdata_i;
      else if (devnum_hit) devnum_q <= wdata_i;
    end
  end

  pnp_index_decode dec_i (
    .idx_i        (idx_q),
    .devnum_hit_o (devnum_hit),
    .field_sel_o  (field_sel)
  );

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_bank
    assign bank_hit[i] = (32'(devnum_q) == i);

    pnp_dev_bank bank_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_i        (data_wr && bank_hit[i]),
      .field_sel_i (field_sel),
      .wdata_i     (wdata_i),
      .cfg_o       (bank_cfg[i]),
      .rd_o        (bank_rd[i])
    );

    assign dev_active_o[i]        = bank_cfg[i].active;
    assign base0_o[i*16 +: 16]    = bank_cfg[i].base0;
    assign base1_o[i*16 +: 16]    = bank_cfg[i].base1;
    assign irq_num_o[i*8 +: 8]    = bank_cfg[i].irq_num;
    assign irq_level_o[i]         = bank_cfg[i].irq_type[0];
    assign irq_invert_o[i]        = bank_cfg[i].irq_type[1];
  end

  assign dev_valid = |bank_hit;

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_DEV; i++) begin
      if (bank_hit[i]) rd_mux = bank_rd[i];
    end
  end

  assign rdata_o = !sel_i     ? idx_q    :
                   devnum_hit ? devnum_q : rd_mux;

  // R2
  idx_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !sel_i |=> idx_q == $past(wdata_i));

  // R3
  devnum_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr && idx_q == IDX_DEVNUM |=> devnum_q == $past(wdata_i));

  // R4
  act_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr && idx_q == IDX_ACT && dev_valid
    |=> dev_active_o[$past(devnum_q[DEV_W-1:0])] == $past(wdata_i[0]));

  // R10
  oor_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr && !dev_valid
    |=> $stable(dev_active_o) && $stable(base0_o) && $stable(base1_o)
        && $stable(irq_num_o) && $stable(irq_level_o) && $stable(irq_invert_o));

  // R10
  oor_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i && !dev_valid && idx_q != IDX_DEVNUM |-> rdata_o == 8'h00);
endmodule

// File: tb/pnp_cfg_regs_tb_top.sv
module pnp_cfg_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_DEV    = 8;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  wr_en = 1'b0;
  logic                  sel = 1'b0;
  logic [7:0]            wdata = '0;
  logic [7:0]            rdata;
  logic [NUM_DEV-1:0]    act, lvl, inv;
  logic [NUM_DEV*16-1:0] b0, b1;
  logic [NUM_DEV*8-1:0]  irqn;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pnp_cfg_regs #(.NUM_DEV(NUM_DEV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .sel_i(sel), .wdata_i(wdata),
    .rdata_o(rdata), .dev_active_o(act), .base0_o(b0), .base1_o(b1),
    .irq_num_o(irqn), .irq_level_o(lvl), .irq_invert_o(inv)
  );

  // entry: {req[3:0], op (1 = read), sel, data / expected}
  localparam int NV = 47;
  localparam logic [13:0] VEC [NV] = '{
    {4'd2, 1'b0, 1'b0, 8'h07}, {4'd2, 1'b1, 1'b0, 8'h07},                        // R2
    {4'd3, 1'b0, 1'b1, 8'h03}, {4'd3, 1'b1, 1'b1, 8'h03},                        // R3
    {4'd4, 1'b0, 1'b0, 8'h30}, {4'd4, 1'b0, 1'b1, 8'hFF}, {4'd4, 1'b1, 1'b1, 8'h01}, // R4
    {4'd5, 1'b0, 1'b0, 8'h60}, {4'd5, 1'b0, 1'b1, 8'h02},                        // R5
    {4'd5, 1'b0, 1'b0, 8'h61}, {4'd5, 1'b0, 1'b1, 8'hF8},
    {4'd5, 1'b0, 1'b0, 8'h62}, {4'd5, 1'b0, 1'b1, 8'h12},
    {4'd5, 1'b0, 1'b0, 8'h63}, {4'd5, 1'b0, 1'b1, 8'h34},
    {4'd5, 1'b0, 1'b0, 8'h60}, {4'd5, 1'b1, 1'b1, 8'h02},
    {4'd5, 1'b0, 1'b0, 8'h63}, {4'd5, 1'b1, 1'b1, 8'h34},
    {4'd6, 1'b0, 1'b0, 8'h70}, {4'd6, 1'b0, 1'b1, 8'h0C}, {4'd6, 1'b1, 1'b1, 8'h0C}, // R6
    {4'd7, 1'b0, 1'b0, 8'h71}, {4'd7, 1'b0, 1'b1, 8'hFE}, {4'd7, 1'b1, 1'b1, 8'h02}, // R7
    {4'd8, 1'b0, 1'b0, 8'h07}, {4'd8, 1'b0, 1'b1, 8'h05},                        // R8
    {4'd8, 1'b0, 1'b0, 8'h70}, {4'd8, 1'b1, 1'b1, 8'h00}, {4'd8, 1'b0, 1'b1, 8'h01},
    {4'd8, 1'b0, 1'b0, 8'h07}, {4'd8, 1'b0, 1'b1, 8'h03},
    {4'd8, 1'b0, 1'b0, 8'h70}, {4'd8, 1'b1, 1'b1, 8'h0C},
    {4'd9, 1'b0, 1'b0, 8'h45}, {4'd9, 1'b0, 1'b1, 8'hAA},                        // R9
    {4'd9, 1'b1, 1'b1, 8'h00}, {4'd9, 1'b1, 1'b0, 8'h45},
    {4'd10, 1'b0, 1'b0, 8'h07}, {4'd10, 1'b0, 1'b1, 8'h09}, {4'd10, 1'b1, 1'b1, 8'h09}, // R10
    {4'd10, 1'b0, 1'b0, 8'h30}, {4'd10, 1'b0, 1'b1, 8'h01}, {4'd10, 1'b1, 1'b1, 8'h00},
    {4'd10, 1'b0, 1'b0, 8'h07}, {4'd10, 1'b0, 1'b1, 8'h07},
    {4'd10, 1'b0, 1'b0, 8'h30}
  };

  task automatic check(input int req, input string what, input logic [127:0] got,
                       input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int req, input logic s, input logic [7:0] exp);
    @(negedge clk);
    sel = s;
    #1;
    check(req, "readback", 128'(rdata), 128'(exp));
  endtask

  task automatic check_all_zero(input string what);
    // R1
    check(1, {what, " active"}, 128'(act), 128'(0));
    check(1, {what, " base0"}, 128'(b0), 128'(0));
    check(1, {what, " base1"}, 128'(b1), 128'(0));
    check(1, {what, " irqnum"}, 128'(irqn), 128'(0));
    check(1, {what, " irqtype"}, 128'({lvl, inv}), 128'(0));
    rd(1, 1'b0, 8'h00);
    wr(1'b0, 8'h07);
    rd(1, 1'b1, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all_zero("reset");

    for (int k = 0; k < NV; k++) begin
      if (VEC[k][9]) rd(int'(VEC[k][13:10]), VEC[k][8], VEC[k][7:0]);
      else           wr(VEC[k][8], VEC[k][7:0]);
    end
    // dev 7: out-of-range activate write must not have landed (R10)
    rd(10, 1'b1, 8'h00);

    @(negedge clk);
    // R4, R10: only device 3 active
    check(4, "active vector", 128'(act), 128'(8'h08));
    // R5
    check(5, "dev3 base0", 128'(b0[3*16 +: 16]), 128'(16'h02F8));
    check(5, "dev3 base1", 128'(b1[3*16 +: 16]), 128'(16'h1234));
    // R6, R8
    check(6, "dev3 irqnum", 128'(irqn[3*8 +: 8]), 128'(8'h0C));
    check(8, "dev5 irqnum", 128'(irqn[5*8 +: 8]), 128'(8'h01));
    check(8, "other irqnums", 128'(irqn & ~{8'h00, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00}),
          128'(0));
    check(8, "other bases", 128'(b0 & ~(128'hFFFF << 48)), 128'(0));
    // R7
    check(7, "level", 128'(lvl), 128'(0));
    check(7, "invert", 128'(inv), 128'(8'h08));
    // R9: write to unimplemented index left device outputs as above
    check(9, "base1 all", 128'(b1), 128'(128'h1234) << 48);

    // mid-run reset
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check_all_zero("mid-run reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule